// File: doc/BRIEF.md
# Two-Stage Mapped Interrupt Controller

This block gathers 64 system events and turns them into 10 host interrupt lines. Events 0 to 31 arrive on external input wires. Events 32 to 63 are raised only by software, through a set register. Every event carries a pending bit. The bit is latched when the event occurs and stays set until software clears it.

Each event passes through two maps. The first is a programmable event-to-channel map with 10 channels. The second is a programmable channel-to-host map with 10 hosts. Hosts 0 and 1 feed the two local processors, and hosts 2 to 9 are wired out to external interrupt controllers.

A fixed priority picks the winning event for each host. Each host presents the index of that winning pending, enabled event together with a valid flag. Each host also drives an interrupt line, which is gated by a per-host enable. A single-cycle register port with write strobe, address, write data and combinational read data sets up all enables and maps.

Top module: `irqm_top`

## Requirements
- R1: A pending bit for an external event (0 to 31) is set only on a rising edge of its input: a change from low to high between two clock edges. A level that is held high sets the bit once. The bit is never set by a level alone. Pending bits read back at address 0x08 (events 0 to 31) and 0x09 (events 32 to 63), with bit n of the word for event 32*k+n.
- R2: A write of an index to the set register at 0x06 sets the pending bit of that event when the index is 32 to 63. Any other index is ignored.
- R3: A write of an index (0 to 63) to the clear register at 0x05 clears that pending bit. If a rising edge of the same external event falls in that same cycle, the event stays pending.
- R4: Event enables sit at 0x00 (events 0 to 31) and 0x01 (events 32 to 63), one bit per event. A pending event whose enable is 0 reaches no host. Its pending bit is still latched.
- R5: The 4-bit channel field of event e sits at address 0x10+e/8, bits 4*(e%8)+3 to 4*(e%8). The 4-bit host field of channel c sits at 0x20+c/8, bits 4*(c%8)+3 to 4*(c%8). A field value of 10 to 15 means unmapped, and an event or channel mapped that way reaches no host.
- R6: For each host, host_vld[h] is 1 when any pending, enabled event reaches it. host_idx[6h+5:6h] then gives the winning event: the lowest channel number wins first, and within that channel the lowest event number wins.
- R7: Host enables sit at 0x04, bit h for host h. host_irq[h] stays 0 while its enable is 0, even when host_vld[h] is 1.
- R8: The host outputs are registered. They change one clock after a pending bit or a configuration register changes. An interrupt line rises one clock after its first qualifying event is latched, and it falls one clock after the last such event is cleared or disabled.
- R9: After reset, all enables, pending bits and map fields read as 0. All host outputs are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_ext | input | 32 | External event inputs, events 0 to 31 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| host_irq | output | 10 | Host interrupt lines, gated by host enable |
| host_vld | output | 10 | A pending, enabled event reaches this host |
| host_idx | output | 60 | Winning event index, 6 bits per host |

## Verification
Two functions can fall in the same clock: a clear write for an event, and a fresh rising edge on that same event's input. The bench provokes this by raising the input in the same cycle as the clear write. The event must stay pending, and a clear issued on its own must still remove it. Priority is judged by how the reported index moves. The bench raises events in different orders across channels and within a channel, then clears the current winner and checks which event takes its place.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    localparam int NUM_EVT   = 64;
    localparam int NUM_EXT   = 32;
    localparam int NUM_CH    = 10;
    localparam int NUM_HOST  = 10;
    localparam int MAP_W     = 4;
    localparam int IDX_W     = $clog2(NUM_EVT);
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int FLD_PER_W = DATA_W / MAP_W;

    localparam logic [ADDR_W-1:0] ADR_EVEN = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_HEN  = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 8'h05;
    localparam logic [ADDR_W-1:0] ADR_SET  = 8'h06;
    localparam logic [ADDR_W-1:0] ADR_PEND = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_CMAP = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_HMAP = 8'h20;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } win_t;
endpackage

// File: rtl/irqm_pend.sv
module irqm_pend
    import irqm_pkg::*;
#(
    parameter int NE = NUM_EVT,
    parameter int NX = NUM_EXT,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NX-1:0] ev_ext,
    input  logic          set_stb,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_stb,
    input  logic [IW-1:0] clr_idx,
    output logic [NE-1:0] pend
);
    logic [NX-1:0] ext_q;
    logic [NX-1:0] rise;
    logic [NE-1:0] pend_d;

    assign rise = ev_ext & ~ext_q;

    always_comb begin
        pend_d = pend;
        for (int e = 0; e < NE; e++) begin
            if (clr_stb && clr_idx == IW'(e)) pend_d[e] = 1'b0;
            if (e < NX) begin
                if (rise[e]) pend_d[e] = 1'b1;
            end else if (set_stb && set_idx == IW'(e)) begin
                pend_d[e] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
            pend  <= '0;
        end else begin
            ext_q <= ev_ext;
            pend  <= pend_d;
        end
    end

    assert_edge_latch_R1: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend[NX-1:0] & $past(rise)) == $past(rise)));

    assert_ext_only_edge_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend[NX-1:0] & ~$past(pend[NX-1:0]) & ~$past(rise)) == '0));

    assert_clear_works_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !(clr_idx < IW'(NX) && rise[clr_idx[$clog2(NX)-1:0]])
                 && !(set_stb && set_idx == clr_idx))
        |=> !pend[$past(clr_idx)]);
endmodule

// File: rtl/irqm_regs.sv
module irqm_regs
    import irqm_pkg::*;
#(
    parameter int NE = NUM_EVT,
    parameter int NX = NUM_EXT,
    parameter int NC = NUM_CH,
    parameter int NH = NUM_HOST,
    parameter int MW = MAP_W,
    parameter int IW = IDX_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [NE-1:0]    pend,
    output logic [DW-1:0]    rdata,
    output logic [NE-1:0]    ev_en,
    output logic [NH-1:0]    host_en,
    output logic [NE*MW-1:0] cmap,
    output logic [NC*MW-1:0] hmap,
    output logic             set_stb,
    output logic [IW-1:0]    set_idx,
    output logic             clr_stb,
    output logic [IW-1:0]    clr_idx
);
    localparam int EN_WORDS = NE / DW;
    localparam int FPW      = DW / MW;

    assign set_stb = we && addr == ADR_SET && wdata >= DW'(NX) && wdata < DW'(NE);
    assign set_idx = wdata[IW-1:0];
    assign clr_stb = we && addr == ADR_CLR && wdata < DW'(NE);
    assign clr_idx = wdata[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_en   <= '0;
            host_en <= '0;
            cmap    <= '0;
            hmap    <= '0;
        end else if (we) begin
            for (int k = 0; k < EN_WORDS; k++)
                if (addr == ADR_EVEN + AW'(k)) ev_en[k*DW +: DW] <= wdata;
            if (addr == ADR_HEN) host_en <= wdata[NH-1:0];
            for (int e = 0; e < NE; e++)
                if (addr == ADR_CMAP + AW'(e / FPW))
                    cmap[e*MW +: MW] <= wdata[(e % FPW)*MW +: MW];
            for (int c = 0; c < NC; c++)
                if (addr == ADR_HMAP + AW'(c / FPW))
                    hmap[c*MW +: MW] <= wdata[(c % FPW)*MW +: MW];
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < EN_WORDS; k++) begin
            if (addr == ADR_EVEN + AW'(k)) rdata = ev_en[k*DW +: DW];
            if (addr == ADR_PEND + AW'(k)) rdata = pend[k*DW +: DW];
        end
        if (addr == ADR_HEN) rdata[NH-1:0] = host_en;
        for (int e = 0; e < NE; e++)
            if (addr == ADR_CMAP + AW'(e / FPW))
                rdata[(e % FPW)*MW +: MW] = cmap[e*MW +: MW];
        for (int c = 0; c < NC; c++)
            if (addr == ADR_HMAP + AW'(c / FPW))
                rdata[(c % FPW)*MW +: MW] = hmap[c*MW +: MW];
    end
endmodule

// File: rtl/irqm_chan.sv
module irqm_chan
    import irqm_pkg::*;
#(
    parameter int NE = NUM_EVT,
    parameter int NC = NUM_CH,
    parameter int MW = MAP_W,
    parameter int IW = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NE-1:0]    act,
    input  logic [NE*MW-1:0] cmap,
    output win_t             ch_win [NC]
);
    for (genvar c = 0; c < NC; c++) begin : g_ch
        logic [NE-1:0] hit;
        always_comb begin
            for (int e = 0; e < NE; e++)
                hit[e] = act[e] && cmap[e*MW +: MW] == MW'(c);
            ch_win[c] = '0;
            for (int e = NE - 1; e >= 0; e--)
                if (hit[e]) begin
                    ch_win[c].vld = 1'b1;
                    ch_win[c].idx = IW'(e);
                end
        end

        assert_chan_winner_R6: assert property (@(posedge clk) disable iff (rst)
            ch_win[c].vld |-> (act[ch_win[c].idx] &&
                               cmap[ch_win[c].idx*MW +: MW] == MW'(c)));
    end
endmodule

// File: rtl/irqm_host.sv
module irqm_host
    import irqm_pkg::*;
#(
    parameter int NC = NUM_CH,
    parameter int NH = NUM_HOST,
    parameter int MW = MAP_W,
    parameter int IW = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  win_t             ch_win [NC],
    input  logic [NC*MW-1:0] hmap,
    input  logic [NH-1:0]    host_en,
    output logic [NH-1:0]    host_irq,
    output logic [NH-1:0]    host_vld,
    output logic [NH*IW-1:0] host_idx
);
    win_t sel [NH];

    for (genvar h = 0; h < NH; h++) begin : g_host
        always_comb begin
            sel[h] = '0;
            for (int c = NC - 1; c >= 0; c--)
                if (ch_win[c].vld && hmap[c*MW +: MW] == MW'(h)) sel[h] = ch_win[c];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                host_irq[h]           <= 1'b0;
                host_vld[h]           <= 1'b0;
                host_idx[h*IW +: IW]  <= '0;
            end else begin
                host_irq[h]           <= sel[h].vld && host_en[h];
                host_vld[h]           <= sel[h].vld;
                host_idx[h*IW +: IW]  <= sel[h].idx;
            end
        end
    end

    assert_host_mask_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((host_irq & ~$past(host_en)) == '0));

    assert_irq_has_winner_R7: assert property (@(posedge clk) disable iff (rst)
        (|host_irq) |-> ((host_irq & ~host_vld) == '0));
endmodule

// File: rtl/irqm_top.sv
module irqm_top
    import irqm_pkg::*;
#(
    parameter int NE = NUM_EVT,
    parameter int NX = NUM_EXT,
    parameter int NC = NUM_CH,
    parameter int NH = NUM_HOST,
    parameter int MW = MAP_W,
    parameter int IW = IDX_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NX-1:0]    ev_ext,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic [NH-1:0]    host_irq,
    output logic [NH-1:0]    host_vld,
    output logic [NH*IW-1:0] host_idx
);
    logic [NE-1:0]    pend;
    logic [NE-1:0]    ev_en;
    logic [NH-1:0]    host_en;
    logic [NE*MW-1:0] cmap;
    logic [NC*MW-1:0] hmap;
    logic             set_stb, clr_stb;
    logic [IW-1:0]    set_idx, clr_idx;
    win_t             ch_win [NC];

    irqm_regs #(.NE(NE), .NX(NX), .NC(NC), .NH(NH), .MW(MW), .IW(IW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .pend(pend), .rdata(cfg_rdata), .ev_en(ev_en), .host_en(host_en),
        .cmap(cmap), .hmap(hmap), .set_stb(set_stb), .set_idx(set_idx),
        .clr_stb(clr_stb), .clr_idx(clr_idx)
    );

    irqm_pend #(.NE(NE), .NX(NX), .IW(IW)) u_pend (
        .clk(clk), .rst(rst), .ev_ext(ev_ext), .set_stb(set_stb), .set_idx(set_idx),
        .clr_stb(clr_stb), .clr_idx(clr_idx), .pend(pend)
    );

    irqm_chan #(.NE(NE), .NC(NC), .MW(MW), .IW(IW)) u_chan (
        .clk(clk), .rst(rst), .act(pend & ev_en), .cmap(cmap), .ch_win(ch_win)
    );

    irqm_host #(.NC(NC), .NH(NH), .MW(MW), .IW(IW)) u_host (
        .clk(clk), .rst(rst), .ch_win(ch_win), .hmap(hmap), .host_en(host_en),
        .host_irq(host_irq), .host_vld(host_vld), .host_idx(host_idx)
    );
endmodule

// File: tb/irqm_top_test.sv
`timescale 1ns/1ps
module irqm_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ev_ext = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [9:0]  host_irq, host_vld;
    logic [59:0] host_idx;

    int n_chk = 0;
    int n_bad = 0;

    irqm_top uut (
        .clk(clk), .rst(rst), .ev_ext(ev_ext), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_irq(host_irq),
        .host_vld(host_vld), .host_idx(host_idx)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse(input int e);
        @(negedge clk);
        ev_ext[e] = 1'b1;
        @(negedge clk);
        ev_ext[e] = 1'b0;
    endtask

    task automatic cleanup();
        wr(8'h00, 0); wr(8'h01, 0); wr(8'h04, 0);
        for (int k = 0; k < 8; k++) wr(8'h10 + 8'(k), 0);
        wr(8'h20, 0); wr(8'h21, 0);
        for (int i = 0; i < 64; i++) wr(8'h05, i);
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R9 host_irq after reset", 64'(host_irq), 0);
        check("R9 host_vld after reset", 64'(host_vld), 0);
        rd(8'h00, d); check("R9 event enable low", 64'(d), 0);
        rd(8'h04, d); check("R9 host enable", 64'(d), 0);
        rd(8'h09, d); check("R9 pending high", 64'(d), 0);
        rd(8'h13, d); check("R9 channel map word", 64'(d), 0);
        rd(8'h21, d); check("R9 host map word", 64'(d), 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        wr(8'h00, 32'h20); wr(8'h04, 32'h1);
        pulse(5);
        rd(8'h08, d); check("R1 pending after edge", 64'(d[5]), 1);
        check("R8 no irq in latch cycle", 64'(host_irq[0]), 0);
        tick();
        check("R8 irq one clock later", 64'(host_irq[0]), 1);
        check("R6 host0 index", 64'(host_idx[5:0]), 5);
        ev_ext[5] = 1'b1; tick(); tick(); tick();
        wr(8'h05, 5);
        rd(8'h08, d); check("R1 held level sets no new pending", 64'(d[5]), 0);
        ev_ext[5] = 1'b0;
        tick();
        check("R8 irq falls after clear", 64'(host_irq[0]), 0);
        pulse(5); tick();
        wr(8'h00, 0);
        check("R8 irq still high in disable cycle", 64'(host_irq[0]), 1);
        tick();
        check("R4 irq falls after event disable", 64'(host_irq[0]), 0);
        cleanup();
    endtask

    task automatic t_disabled_event();
        logic [31:0] d;
        wr(8'h04, 32'h3FF);
        pulse(7); tick();
        rd(8'h08, d); check("R4 disabled event still pending", 64'(d[7]), 1);
        check("R4 disabled event reaches no host", 64'(host_vld), 0);
        cleanup();
    endtask

    task automatic t_host_enable();
        wr(8'h10, 32'h2000); wr(8'h20, 32'h400); wr(8'h00, 32'h8);
        pulse(3); tick();
        check("R5 routed to host4", 64'(host_vld), 64'h10);
        check("R6 host4 index", 64'(host_idx[29:24]), 3);
        check("R7 disabled host stays low", 64'(host_irq), 0);
        wr(8'h04, 32'h10); tick();
        check("R7 host enabled asserts", 64'(host_irq), 64'h10);
        wr(8'h04, 0); tick();
        check("R8 host disable drops irq", 64'(host_irq), 0);
        cleanup();
    endtask

    task automatic t_prio_in_chan();
        wr(8'h01, 32'h108); wr(8'h04, 32'h1);
        wr(8'h06, 40); tick();
        check("R2 set raises event 40", 64'(host_idx[5:0]), 40);
        wr(8'h06, 35); tick();
        check("R6 lower event wins in channel", 64'(host_idx[5:0]), 35);
        wr(8'h05, 35); tick();
        check("R6 next event after clear", 64'(host_idx[5:0]), 40);
        check("R6 still valid", 64'(host_vld[0]), 1);
        cleanup();
    endtask

    task automatic t_prio_chan();
        wr(8'h10, 32'h300); wr(8'h16, 32'h100); wr(8'h20, 32'h6060);
        wr(8'h00, 32'h4); wr(8'h01, 32'h40000); wr(8'h04, 32'h40);
        pulse(2); tick();
        check("R6 single event on host6", 64'(host_idx[41:36]), 2);
        wr(8'h06, 50); tick();
        check("R6 lower channel beats lower event", 64'(host_idx[41:36]), 50);
        wr(8'h05, 50); tick();
        check("R6 falls back to channel 3 event", 64'(host_idx[41:36]), 2);
        check("R6 irq on host6", 64'(host_irq), 64'h40);
        cleanup();
    endtask

    task automatic t_unmapped();
        wr(8'h00, 32'h200); wr(8'h04, 32'h3FF); wr(8'h11, 32'hC0);
        pulse(9); tick();
        check("R5 unmapped event reaches no host", 64'(host_vld), 0);
        wr(8'h11, 32'h50); wr(8'h20, 32'hB00000); tick();
        check("R5 unmapped channel reaches no host", 64'(host_vld), 0);
        wr(8'h20, 32'h700000); tick();
        check("R5 channel5 to host7", 64'(host_irq), 64'h80);
        check("R6 host7 index", 64'(host_idx[47:42]), 9);
        cleanup();
    endtask

    task automatic t_set_ignored();
        logic [31:0] d;
        wr(8'h06, 4);
        rd(8'h08, d); check("R2 set below 32 ignored", 64'(d), 0);
        wr(8'h06, 63);
        rd(8'h09, d); check("R2 set of event 63", 64'(d), 64'h80000000);
        cleanup();
    endtask

    task automatic t_clear_collide();
        logic [31:0] d;
        pulse(6);
        @(negedge clk);
        ev_ext[6] = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h05; cfg_wdata = 6;
        @(negedge clk);
        cfg_we = 1'b0; ev_ext[6] = 1'b0;
        rd(8'h08, d); check("R3 edge wins over same-cycle clear", 64'(d[6]), 1);
        wr(8'h05, 6);
        rd(8'h08, d); check("R3 clear alone removes pending", 64'(d[6]), 0);
        cleanup();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_basic();
        t_disabled_event();
        t_host_enable();
        t_prio_in_chan();
        t_prio_chan();
        t_unmapped();
        t_set_ignored();
        t_clear_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule